// File: doc/BRIEF.md
# Filter Corner Configuration Master

This block sits on the host side of a programmable low-pass filter. A single request names a cutoff between 1 and 28 MHz and one of three gain settings. The block turns the request into three configuration bytes: a corner byte, a resistor trim and a gain trim. It writes them to the filter over a three-wire serial link, one framed write per byte. It then pulses the filter's calibration enable, waits for the filter to report that it is tuned, and reports the result.

The link has three wires: a serial clock, a data line and an active-low latch enable. The serial clock comes from an even divider of the system clock and runs only while latch enable is low. Each frame is 16 bits, sent most significant bit first. Data changes only on falling serial-clock edges, and the rising edge of latch enable commits the frame. The calibration pulse is issued only after all three frames have been committed and a minimum spacing has passed. Once the tuned flag is seen, the reference clock enable is dropped so the reference oscillator can be gated off. If the flag does not arrive within a window counted in reference periods, a timeout is flagged and the reference clock stays enabled. The filter is expected to drop its tuned flag while calibration enable is high.

Top module: `filter_cfg_master`

## Requirements
- R1: Reset state:
  - latch enable is high;
  - serial clock, calibration enable, busy, done and both error flags are low;
  - reference clock enable is high.
- R2: An accepted request produces exactly three write frames, for addresses 0, 1 and 2 in that order. Each frame carries 16 bits, most significant bit first:
  - bit 15 = 1;
  - bits 14:13 = 00;
  - bit 12 = 0, meaning write;
  - bits 11:8 = address;
  - bits 7:0 = data.
- R3: The address 0 byte comes from the corner table, for example 1→0x0F, 11→0x64, 14→0x7D, 18→0xA4, 20→0xB5, 28→0xF0. The address 1 byte is the resistor trim R:
  - R = cutoff for cutoffs 1 to 10;
  - R = cutoff+1 for cutoffs 11 to 17;
  - R = cutoff+2 for cutoffs 18 to 28.
- R4: The address 2 byte depends on the gain code:
  - code 2 (6 dB) gives R;
  - code 1 (3 dB) gives floor((R·181+128)/256);
  - code 0 (0 dB) gives floor((R+1)/2).
- R5: The serial clock toggles only while latch enable is low. It stays high for SCLK_HALF system cycles per pulse. Data is stable while the serial clock is high.
- R6: Between frames, latch enable stays high for at least LE_GAP system cycles.
- R7: Calibration enable rises only after the third frame has been committed, and at least CAL_SETUP cycles after the last latch-enable rise. It then stays high for exactly CAL_HI cycles.
- R8: The tuned input passes through a two-stage synchronizer. While the block is waiting, done rises on the third clock edge after the tuned input rises. On that same edge, reference clock enable falls and busy falls.
- R9: The timeout window is TUNE_REFS·REF_CYC cycles. If no synchronized tuned flag arrives within it, the timeout error rises exactly that many edges after calibration enable falls. Reference clock enable stays high.
- R10: A request is rejected if its cutoff is 0 or above 28, or its gain code is 3. A rejected request sets the range error on the next edge, starts no bus traffic and leaves busy low.
- R11: A request made while the block is busy is ignored, and the frames in flight are unchanged.
- R12: Status flags hold until the next request taken while idle. That request clears them. If it is accepted, it also raises busy and reference clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_mhz_i | input | 5 | Requested cutoff in MHz |
| req_gain_i | input | 2 | Gain code: 0=0 dB, 1=3 dB, 2=6 dB |
| tuned_i | input | 1 | Tuned flag from the filter (asynchronous) |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| sle_o | output | 1 | Latch enable, low during a frame |
| cal_en_o | output | 1 | Calibration enable pulse |
| ref_clk_en_o | output | 1 | Reference clock enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Tuning confirmed |
| err_timeout_o | output | 1 | Tuned flag not seen in time |
| err_range_o | output | 1 | Request rejected |

## Verification
Results fall due at fixed times:
- The range error and the clearing of status flags appear one edge after the request strobe.
- Done appears on the third edge after the tuned input rises.
- The timeout error appears exactly TUNE_REFS·REF_CYC edges after calibration enable falls.

The bench drives inputs on falling clock edges and samples outputs on the falling edge that follows the counted number of rising edges. It also checks one falling edge earlier that the result has not yet appeared. Frame contents, the latch-to-calibration spacing and the serial-clock shape are taken by a passive serial receiver and an edge monitor. Those results are compared against values computed from the requirements.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

  localparam int MHZ_W   = 5;
  localparam int FRAME_W = 16;
  localparam int MHZ_MAX = 28;

  localparam logic [1:0] GSEL_0DB = 2'd0;
  localparam logic [1:0] GSEL_3DB = 2'd1;
  localparam logic [1:0] GSEL_6DB = 2'd2;

  typedef struct packed {
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
  } cfg_bytes_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] corner_byte(input logic [MHZ_W-1:0] mhz);
    logic [7:0] v;
    unique case (mhz)
      5'd1:  v = 8'h0F;  5'd2:  v = 8'h17;  5'd3:  v = 8'h1F;  5'd4:  v = 8'h27;
      5'd5:  v = 8'h2F;  5'd6:  v = 8'h37;  5'd7:  v = 8'h3F;  5'd8:  v = 8'h47;
      5'd9:  v = 8'h4F;  5'd10: v = 8'h57;  5'd11: v = 8'h64;  5'd12: v = 8'h6C;
      5'd13: v = 8'h75;  5'd14: v = 8'h7D;  5'd15: v = 8'h80;  5'd16: v = 8'h88;
      5'd17: v = 8'h90;  5'd18: v = 8'hA4;  5'd19: v = 8'hAC;  5'd20: v = 8'hB5;
      5'd21: v = 8'hBD;  5'd22: v = 8'hC5;  5'd23: v = 8'hCD;  5'd24: v = 8'hDC;
      5'd25: v = 8'hE4;  5'd26: v = 8'hEC;  5'd27: v = 8'hF4;  5'd28: v = 8'hF0;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // trim skips codes above 10 and above 17
  function automatic logic [7:0] res_trim(input logic [MHZ_W-1:0] mhz);
    logic [7:0] m;
    m = 8'(mhz);
    if (mhz <= 5'd10)      return m;
    else if (mhz <= 5'd17) return m + 8'd1;
    else                   return m + 8'd2;
  endfunction

endpackage

// File: rtl/cfg_lut.sv
module cfg_lut
  import fcm_pkg::*;
(
  input  logic [MHZ_W-1:0] mhz_i,
  input  logic [1:0]       gain_i,
  output logic             ok_o,
  output cfg_bytes_t       bytes_o
);
  logic [7:0]  res;
  logic [15:0] prod;

  always_comb begin
    res        = res_trim(mhz_i);
    prod       = 16'(res) * 16'd181 + 16'd128;  // x/sqrt2, rounded
    bytes_o.b0 = corner_byte(mhz_i);
    bytes_o.b1 = res;
    unique case (gain_i)
      GSEL_0DB: bytes_o.b2 = (res + 8'd1) >> 1;
      GSEL_3DB: bytes_o.b2 = prod[15:8];
      default:  bytes_o.b2 = res;
    endcase
    ok_o = (mhz_i != '0) && (mhz_i <= MHZ_W'(MHZ_MAX)) && (gain_i != 2'd3);
  end
endmodule

// File: rtl/sync_stages.sv
module sync_stages #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int W    = 16,
  parameter int HALF = 4,
  parameter int GAP  = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         sclk_o,
  output logic         sdata_o,
  output logic         sle_o,
  output logic         done_o
);
  localparam int BW = $clog2(W);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

  typedef enum logic [1:0] {FT_IDLE, FT_SHIFT, FT_GAP} ft_st_e;

  ft_st_e        st_q;
  logic [W-1:0]  sh_q;
  logic [BW-1:0] bit_q;
  logic [GW-1:0] gap_q;
  logic          run, rise, fall;

  assign run = (st_q == FT_SHIFT);

  sclk_gen #(.HALF(HALF)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FT_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      gap_q <= '0;
    end else begin
      unique case (st_q)
        FT_IDLE: if (start_i) begin
          sh_q  <= word_i;
          bit_q <= '0;
          st_q  <= FT_SHIFT;
        end
        FT_SHIFT: if (fall) begin
          sh_q <= sh_q << 1;
          if (bit_q == BW'(W - 1)) begin
            st_q  <= FT_GAP;
            gap_q <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        FT_GAP: begin
          if (gap_q == GW'(GAP - 1)) st_q <= FT_IDLE;
          else                       gap_q <= gap_q + 1'b1;
        end
        default: st_q <= FT_IDLE;
      endcase
    end
  end

  assign sdata_o = sh_q[W-1];
  assign sle_o   = !run;
  assign done_o  = (st_q == FT_GAP) && (gap_q == GW'(GAP - 1));

  logic unused_rise;
  assign unused_rise = rise;
endmodule

// File: rtl/filter_cfg_master.sv
module filter_cfg_master
  import fcm_pkg::*;
#(
  parameter int SCLK_HALF = 4,
  parameter int LE_GAP    = 4,
  parameter int CAL_SETUP = 4,
  parameter int CAL_HI    = 8,
  parameter int TUNE_REFS = 64,
  parameter int REF_CYC   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [MHZ_W-1:0] req_mhz_i,
  input  logic [1:0]       req_gain_i,
  input  logic             tuned_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             sle_o,
  output logic             cal_en_o,
  output logic             ref_clk_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_timeout_o,
  output logic             err_range_o
);
  localparam int TO_CYC = TUNE_REFS * REF_CYC;
  localparam int CMAX   = imax(TO_CYC, imax(CAL_SETUP, CAL_HI));
  localparam int CNT_W  = $clog2(CMAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_CSET, ST_CHI, ST_WAIT} st_e;

  st_e             st_q;
  logic [1:0]      idx_q;
  cfg_bytes_t      cfg_q, lut_bytes;
  logic            lut_ok;
  logic            start_q, ftx_done, tuned_s;
  logic [CNT_W-1:0] cnt_q;
  logic            cal_q, done_q, terr_q, rerr_q, refen_q;
  logic [7:0]      dbyte;
  logic [FRAME_W-1:0] word;

  cfg_lut u_lut (
    .mhz_i  (req_mhz_i),
    .gain_i (req_gain_i),
    .ok_o   (lut_ok),
    .bytes_o(lut_bytes)
  );

  sync_stages #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tuned_i),
    .q_o   (tuned_s)
  );

  always_comb begin
    unique case (idx_q)
      2'd0:    dbyte = cfg_q.b0;
      2'd1:    dbyte = cfg_q.b1;
      default: dbyte = cfg_q.b2;
    endcase
  end

  // start, 2 zero bits, write=0, 4-bit address, data
  assign word = {1'b1, 2'b00, 1'b0, 2'b00, idx_q, dbyte};

  frame_tx #(.W(FRAME_W), .HALF(SCLK_HALF), .GAP(LE_GAP)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .word_i (word),
    .sclk_o (sclk_o),
    .sdata_o(sdata_o),
    .sle_o  (sle_o),
    .done_o (ftx_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      cfg_q   <= '0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      cal_q   <= 1'b0;
      done_q  <= 1'b0;
      terr_q  <= 1'b0;
      rerr_q  <= 1'b0;
      refen_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          done_q <= 1'b0;
          terr_q <= 1'b0;
          if (!lut_ok) begin
            rerr_q <= 1'b1;
          end else begin
            rerr_q  <= 1'b0;
            refen_q <= 1'b1;
            cfg_q   <= lut_bytes;
            idx_q   <= '0;
            start_q <= 1'b1;
            st_q    <= ST_SEND;
          end
        end
        ST_SEND: if (ftx_done) begin
          if (idx_q == 2'd2) begin
            st_q  <= ST_CSET;
            cnt_q <= '0;
          end else begin
            idx_q   <= idx_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        ST_CSET: begin
          if (cnt_q == CNT_W'(CAL_SETUP - 1)) begin
            cal_q <= 1'b1;
            cnt_q <= '0;
            st_q  <= ST_CHI;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CHI: begin
          if (cnt_q == CNT_W'(CAL_HI - 1)) begin
            cal_q <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_WAIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WAIT: begin
          if (tuned_s) begin
            done_q  <= 1'b1;
            refen_q <= 1'b0;
            st_q    <= ST_IDLE;
          end else if (cnt_q == CNT_W'(TO_CYC - 1)) begin
            terr_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cal_en_o      = cal_q;
  assign ref_clk_en_o  = refen_q;
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_timeout_o = terr_q;
  assign err_range_o   = rerr_q;
endmodule

// File: rtl/filter_cfg_master_chk.sv
module filter_cfg_master_chk #(
  parameter int LE_GAP    = 4,
  parameter int CAL_SETUP = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [4:0] req_mhz_i,
  input logic [1:0] req_gain_i,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       sle_o,
  input logic       cal_en_o,
  input logic       ref_clk_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_timeout_o,
  input logic       err_range_o
);
  logic [15:0] hi_cnt;
  logic [2:0]  frm_cnt;
  logic        le_d;
  logic        bad_req;

  assign bad_req = (req_mhz_i == 5'd0) || (req_mhz_i > 5'd28) || (req_gain_i == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '1;
      frm_cnt <= '0;
      le_d    <= 1'b1;
    end else begin
      le_d <= sle_o;
      if (!sle_o)              hi_cnt <= '0;
      else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
      if (req_valid_i && !busy_o)                      frm_cnt <= '0;
      else if (sle_o && !le_d && frm_cnt != 3'd7)      frm_cnt <= frm_cnt + 1'b1;
    end
  end

  p_sclk_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !sle_o);

  p_data_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o));

  p_le_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sle_o) |-> (hi_cnt >= 16'(LE_GAP)));

  p_cal_after_frames_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_en_o) |-> (frm_cnt == 3'd3 && hi_cnt >= 16'(CAL_SETUP)));

  p_done_gates_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!ref_clk_en_o && !busy_o));

  p_timeout_keeps_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timeout_o |-> ref_clk_en_o);

  p_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && bad_req) |=> (err_range_o && !busy_o && sle_o));

  p_flags_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_timeout_o));
endmodule

bind filter_cfg_master filter_cfg_master_chk #(
  .LE_GAP   (LE_GAP),
  .CAL_SETUP(CAL_SETUP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_mhz_i    (req_mhz_i),
  .req_gain_i   (req_gain_i),
  .sclk_o       (sclk_o),
  .sdata_o      (sdata_o),
  .sle_o        (sle_o),
  .cal_en_o     (cal_en_o),
  .ref_clk_en_o (ref_clk_en_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_timeout_o(err_timeout_o),
  .err_range_o  (err_range_o)
);

// File: tb/filter_cfg_master_test.sv
module filter_cfg_master_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  SCLK_HALF = 2;
  localparam int  LE_GAP    = 3;
  localparam int  CAL_SETUP = 3;
  localparam int  CAL_HI    = 4;
  localparam int  TUNE_REFS = 64;
  localparam int  REF_CYC   = 4;
  localparam int  TO_CYC    = TUNE_REFS * REF_CYC;
  localparam real TCK       = 5.0;

  logic       clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, tuned = 1'b0;
  logic [4:0] req_mhz = '0;
  logic [1:0] req_gain = '0;
  logic sclk, sdata, sle, cal_en, ref_en, busy, done, err_to, err_rng;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  filter_cfg_master #(
    .SCLK_HALF(SCLK_HALF), .LE_GAP(LE_GAP), .CAL_SETUP(CAL_SETUP),
    .CAL_HI(CAL_HI), .TUNE_REFS(TUNE_REFS), .REF_CYC(REF_CYC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mhz_i(req_mhz),
    .req_gain_i(req_gain), .tuned_i(tuned), .sclk_o(sclk), .sdata_o(sdata),
    .sle_o(sle), .cal_en_o(cal_en), .ref_clk_en_o(ref_en), .busy_o(busy),
    .done_o(done), .err_timeout_o(err_to), .err_range_o(err_rng)
  );

  // passive serial receiver
  logic [15:0] sl_sh = '0;
  int          sl_bits = 0, nfr = 0, nfr_at_cal = 0, le_gap_bad = 0, edge_bad = 0;
  logic [15:0] frm [0:63];
  int          frm_bits [0:63];
  realtime     t_le_rise = 0, t_cal_rise = 0, t_cal_fall = 0;

  always @(posedge sclk) if (sle === 1'b0) begin
    sl_sh = {sl_sh[14:0], sdata};
    sl_bits++;
  end

  always @(posedge sle) if (sl_bits > 0) begin
    if (nfr < 64) begin
      frm[nfr]      = sl_sh;
      frm_bits[nfr] = sl_bits;
    end
    nfr++;
    sl_bits   = 0;
    t_le_rise = $realtime;
  end

  always @(negedge sle) if (nfr > 0 && ($realtime - t_le_rise) < LE_GAP * TCK) le_gap_bad++;
  always @(posedge cal_en) begin t_cal_rise = $realtime; nfr_at_cal = nfr; end
  always @(negedge cal_en) t_cal_fall = $realtime;

  // serial clock shape monitor
  logic p_sclk = 1'b0, p_sdata = 1'b0;
  int   hi_run = 0;
  always @(negedge clk) begin
    if (sclk === 1'b1 && p_sclk === 1'b1 && sdata !== p_sdata) edge_bad++;
    if (sclk === 1'b1 && sle !== 1'b0) edge_bad++;
    if (sclk === 1'b1) hi_run++;
    else begin
      if (p_sclk === 1'b1 && hi_run != SCLK_HALF) edge_bad++;
      hi_run = 0;
    end
    p_sclk  = sclk;
    p_sdata = sdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wexp(input int a, input logic [7:0] d);
    return {4'b1000, 4'(a), d};
  endfunction

  task automatic send_req(input logic [4:0] m, input logic [1:0] g);
    @(negedge clk);
    req_mhz = m; req_gain = g; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sle", sle, 1);       chk("R1 sclk", sclk, 0);
    chk("R1 cal_en", cal_en, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);     chk("R1 err_timeout", err_to, 0);
    chk("R1 err_range", err_rng, 0); chk("R1 ref_clk_en", ref_en, 1);
  endtask

  task automatic run_cfg(input logic [4:0] m, input logic [1:0] g,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input bit inject);
    int n0, eb0, lg0;
    n0 = nfr; eb0 = edge_bad; lg0 = le_gap_bad;
    tuned = 1'b0;
    send_req(m, g);
    chk("R12 busy after accept", busy, 1);
    chk("R12 ref_clk_en raised", ref_en, 1);
    chk("R12 done cleared", done, 0);
    chk("R12 err_range cleared", err_rng, 0);
    if (inject) begin
      repeat (20) @(negedge clk);
      chk("R11 busy mid-frame", busy, 1);
      send_req(5'd3, 2'd0);
    end
    @(posedge cal_en); #1;
    chk("R7 frames before cal", nfr_at_cal - n0, 3);
    for (int i = 0; i < 3; i++) chk("R2 frame length", frm_bits[n0+i], 16);
    chk("R3 address 0 frame", frm[n0],   wexp(0, b0));
    chk("R3 address 1 frame", frm[n0+1], wexp(1, b1));
    chk("R4 address 2 frame", frm[n0+2], wexp(2, b2));
    if (inject) chk("R11 in-flight gain frame kept", frm[n0+2], wexp(2, b2));
    chk("R7 latch-to-cal spacing", ((t_cal_rise - t_le_rise) >= CAL_SETUP * TCK) ? 1 : 0, 1);
    @(negedge cal_en); #1;
    chk("R7 cal high width", int'((t_cal_fall - t_cal_rise) / TCK), CAL_HI);
    repeat (6) @(negedge clk);
    chk("R8 not done before tuned", done, 0);
    tuned = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 done not early", done, 0);
    @(negedge clk);
    chk("R8 done", done, 1);
    chk("R8 ref clock gated", ref_en, 0);
    chk("R8 idle", busy, 0);
    chk("R5 serial clock shape", edge_bad - eb0, 0);
    chk("R6 latch gap", le_gap_bad - lg0, 0);
    if (inject) chk("R11 exactly three frames", nfr - n0, 3);
  endtask

  task automatic t_range(input logic [4:0] m, input logic [1:0] g);
    int n0, viol;
    n0 = nfr; viol = 0;
    send_req(m, g);
    chk("R10 err_range set", err_rng, 1);
    chk("R10 stays idle", busy, 0);
    chk("R12 done cleared by request", done, 0);
    repeat (40) begin
      @(negedge clk);
      if (sle !== 1'b1 || busy !== 1'b0 || cal_en !== 1'b0) viol++;
    end
    chk("R10 no bus traffic", viol, 0);
    chk("R10 no frames", nfr - n0, 0);
  endtask

  task automatic t_timeout();
    tuned = 1'b0;
    send_req(5'd5, 2'd2);
    @(negedge cal_en);
    @(negedge clk);
    repeat (TO_CYC - 1) @(negedge clk);
    chk("R9 no early timeout", err_to, 0);
    @(negedge clk);
    chk("R9 timeout flagged", err_to, 1);
    chk("R9 ref clock kept", ref_en, 1);
    chk("R9 done low", done, 0);
    chk("R9 idle", busy, 0);
    send_req(5'd14, 2'd2);
    chk("R12 timeout cleared", err_to, 0);
    chk("R12 busy", busy, 1);
    @(posedge cal_en);
    @(negedge cal_en);
    repeat (3) @(negedge clk);
    tuned = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 done after retry", done, 1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 sequence hung act=%0d exp=0", 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cfg(5'd1,  2'd0, 8'h0F, 8'h01, 8'h01, 1'b0);
    t_range(5'd0,  2'd0);
    run_cfg(5'd14, 2'd2, 8'h7D, 8'h0F, 8'h0F, 1'b0);
    run_cfg(5'd14, 2'd1, 8'h7D, 8'h0F, 8'h0B, 1'b0);
    run_cfg(5'd14, 2'd0, 8'h7D, 8'h0F, 8'h08, 1'b0);
    run_cfg(5'd28, 2'd2, 8'hF0, 8'h1E, 8'h1E, 1'b0);
    run_cfg(5'd28, 2'd1, 8'hF0, 8'h1E, 8'h15, 1'b0);
    run_cfg(5'd20, 2'd0, 8'hB5, 8'h16, 8'h0B, 1'b0);
    run_cfg(5'd11, 2'd0, 8'h64, 8'h0C, 8'h06, 1'b0);
    run_cfg(5'd18, 2'd1, 8'hA4, 8'h14, 8'h0E, 1'b0);
    t_range(5'd29, 2'd2);
    t_range(5'd31, 2'd1);
    t_range(5'd10, 2'd3);
    t_timeout();
    run_cfg(5'd14, 2'd1, 8'h7D, 8'h0F, 8'h0B, 1'b1);
    finish_run();
  end
endmodule